// File: doc/BRIEF.md
# Counted Pulse Burst Generator for a DAC

This block feeds a 14-bit offset-binary DAC with a finite burst of rectangular pulses, as the transmit side of a time-domain reflectometer. A one-cycle start strobe captures four settings: how many clock cycles each pulse stays high, how many cycles one period lasts, how many pulses the burst holds and how far above mid-scale the pulse goes. The block then plays the burst and stops on its own. Outside the high phase of a pulse, the DAC sits at its mid-scale code, which stands for zero volts.

A one-cycle marker accompanies the first high sample of every pulse, so that a receive path can line up its sampling window with the pulse. The write enable covers the whole burst and one more cycle, so that the final zero-level sample reaches the converter. A soft-reset strobe stops a burst at any point and returns the output to mid-scale at the next clock edge.

Top module: `pulse_train_gen`

## Requirements
- R1: After the asynchronous reset is released, `dac_data_o` is 8192, and `dac_we_o`, `busy_o` and `pulse_start_o` are all 0.
- R2: A start strobe seen at clock edge k, while the block is idle and the captured count and period are both nonzero, sets `busy_o` from edge k onward. The four configuration inputs are sampled at that edge.
- R3: Number the burst cycles t = 0, 1, 2 and so on from edge k. After edge k+1+t, for t below count*period, `dac_data_o` carries the high level when (t mod period) < width and carries 8192 otherwise. A width of 0 gives no pulses.
- R4: When width is greater than or equal to period, the output stays at the high level for every cycle of the burst.
- R5: `busy_o` stays 1 for exactly count*period cycles and then falls by itself. After that, `dac_data_o` stays at 8192.
- R6: The high level is 8192 plus the height, saturated at 16383. For example, a height of 8190 gives 16382, and heights of 8191 or more give 16383.
- R7: `pulse_start_o` is 1 for one cycle, after edge k+1+t, for every t below count*period with t mod period equal to 0, provided the width is nonzero. At all other times it is 0.
- R8: `dac_we_o` is 1 after edges k+1 through k+1+count*period, which is the whole burst plus one trailing zero-level cycle, and 0 at all other times. While it is 0, `dac_data_o` is 8192.
- R9: A soft-reset strobe seen at an edge sets `dac_data_o` to 8192 and clears `busy_o` and `pulse_start_o` after that same edge. `dac_we_o` is 1 for that single cycle only if a burst was running, so that the zero level is loaded.
- R10: A start strobe has no effect when it arrives during a burst, when it comes together with soft reset, or when the count or the period is 0.
- R11: Changes to the configuration inputs during a burst do not alter the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle burst launch strobe |
| soft_rst_i | input | 1 | One-cycle abort and clear strobe |
| cfg_width_i | input | 32 | High-phase length in cycles |
| cfg_period_i | input | 32 | Period length in cycles |
| cfg_count_i | input | 16 | Number of pulses in the burst |
| cfg_height_i | input | 14 | Pulse amplitude above mid-scale |
| dac_data_o | output | 14 | Offset-binary DAC code |
| dac_we_o | output | 1 | DAC write enable |
| busy_o | output | 1 | Burst in progress |
| pulse_start_o | output | 1 | Marks the first high sample of each pulse |

## Verification
Random bursts with short widths, periods and counts are compared cycle by cycle against a bench model. These runs separate the duty-cycle and wrap-around logic from the pulse counter, and in many of them a start strobe and new settings are injected mid-burst to show that the captured configuration holds. Directed bursts cover cases the random mix reaches too rarely to rely on. A width equal to or above the period tests the full-high case. Heights on either side of the clip point test the saturation. A zero width, a zero count and a zero period test the degenerate trains. A soft reset mid-burst, combined with a start strobe in the same cycle, tests the abort path and the one-cycle write of the zero level.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/ptg_level.sv
module ptg_level #(
  parameter int unsigned DAC_W = 14
) (
  input  logic [DAC_W-1:0] height_i,
  input  logic             high_i,
  output logic [DAC_W-1:0] code_o
);
  localparam logic [DAC_W-1:0] MID_CODE = {1'b1, {(DAC_W-1){1'b0}}};
  localparam logic [DAC_W-1:0] MAX_CODE = {DAC_W{1'b1}};

  logic [DAC_W:0] sum;

  always_comb begin
    sum = {1'b0, MID_CODE} + {1'b0, height_i};
    if (!high_i)
      code_o = MID_CODE;
    else if (sum[DAC_W])
      code_o = MAX_CODE;
    else
      code_o = sum[DAC_W-1:0];
  end
endmodule

// File: rtl/ptg_sequencer.sv
module ptg_sequencer
  import ptg_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NUM_W = 16,
  parameter int unsigned DAC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             soft_rst_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [NUM_W-1:0] count_i,
  input  logic [DAC_W-1:0] height_i,
  output logic             busy_o,
  output logic             high_o,
  output logic             first_o,
  output logic [DAC_W-1:0] height_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [NUM_W-1:0] NUM_ONE = {{(NUM_W-1){1'b0}}, 1'b1};

  run_state_e       state_q, state_d;
  logic [CNT_W-1:0] phase_q, phase_d, phase_inc;
  logic [NUM_W-1:0] done_q, done_d, done_inc;
  logic [CNT_W-1:0] width_q, period_q;
  logic [NUM_W-1:0] count_q;
  logic [DAC_W-1:0] height_q;
  logic             launch, phase_last, train_last;

  always_comb begin
    launch     = start_i && !soft_rst_i && (state_q == ST_IDLE) &&
                 (count_i != '0) && (period_i != '0);
    phase_inc  = phase_q + CNT_ONE;
    done_inc   = done_q + NUM_ONE;
    phase_last = (phase_inc == period_q);
    train_last = phase_last && (done_inc == count_q);
    state_d    = state_q;
    phase_d    = phase_q;
    done_d     = done_q;
    if (soft_rst_i) begin
      state_d = ST_IDLE;
      phase_d = '0;
      done_d  = '0;
    end else if (launch) begin
      state_d = ST_RUN;
      phase_d = '0;
      done_d  = '0;
    end else if (state_q == ST_RUN) begin
      if (phase_last) begin
        phase_d = '0;
        done_d  = done_inc;
        if (train_last) begin
          state_d = ST_IDLE;
          done_d  = '0;
        end
      end else begin
        phase_d = phase_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      done_q  <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q  <= '0;
      period_q <= '0;
      count_q  <= '0;
      height_q <= '0;
    end else if (launch) begin
      width_q  <= width_i;
      period_q <= period_i;
      count_q  <= count_i;
      height_q <= height_i;
    end
  end

  assign busy_o   = (state_q == ST_RUN);
  assign high_o   = busy_o && (phase_q < width_q);
  assign first_o  = busy_o && (phase_q == '0) && (width_q != '0);
  assign height_o = height_q;

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (phase_q < period_q)); // R3
  AST_TRAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (done_q < count_q)); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(width_q) && $stable(period_q) && $stable(height_q))); // R11
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
  parameter int unsigned DAC_W = 14,
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             soft_rst_i,
  input  logic [CNT_W-1:0] cfg_width_i,
  input  logic [CNT_W-1:0] cfg_period_i,
  input  logic [NUM_W-1:0] cfg_count_i,
  input  logic [DAC_W-1:0] cfg_height_i,
  output logic [DAC_W-1:0] dac_data_o,
  output logic             dac_we_o,
  output logic             busy_o,
  output logic             pulse_start_o
);
  localparam logic [DAC_W-1:0] MID_CODE = {1'b1, {(DAC_W-1){1'b0}}};

  logic             busy, high, first;
  logic [DAC_W-1:0] height, level;
  logic             busy_prev_q, busy_prev_d;
  logic [DAC_W-1:0] data_q, data_d;
  logic             we_q, we_d, mark_q, mark_d;

  ptg_sequencer #(.CNT_W(CNT_W), .NUM_W(NUM_W), .DAC_W(DAC_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .soft_rst_i (soft_rst_i),
    .width_i    (cfg_width_i),
    .period_i   (cfg_period_i),
    .count_i    (cfg_count_i),
    .height_i   (cfg_height_i),
    .busy_o     (busy),
    .high_o     (high),
    .first_o    (first),
    .height_o   (height)
  );

  ptg_level #(.DAC_W(DAC_W)) u_level (
    .height_i (height),
    .high_i   (high),
    .code_o   (level)
  );

  always_comb begin
    if (soft_rst_i) begin
      data_d      = MID_CODE;
      we_d        = busy;
      mark_d      = 1'b0;
      busy_prev_d = 1'b0;
    end else begin
      data_d      = level;
      we_d        = busy || busy_prev_q;
      mark_d      = first;
      busy_prev_d = busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q      <= MID_CODE;
      we_q        <= 1'b0;
      mark_q      <= 1'b0;
      busy_prev_q <= 1'b0;
    end else begin
      data_q      <= data_d;
      we_q        <= we_d;
      mark_q      <= mark_d;
      busy_prev_q <= busy_prev_d;
    end
  end

  assign dac_data_o    = data_q;
  assign dac_we_o      = we_q;
  assign pulse_start_o = mark_q;
  assign busy_o        = busy;

  AST_REST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_we_o |-> (dac_data_o == MID_CODE)); // R8
  AST_TAIL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> dac_we_o); // R8
  AST_MARK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_start_o |-> dac_we_o); // R7
  AST_NOT_BELOW_MID: assert property (@(posedge clk) disable iff (!rst_n)
    dac_data_o >= MID_CODE); // R6
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (!busy_o && !pulse_start_o && dac_data_o == MID_CODE)); // R9
endmodule

// File: tb/pulse_train_gen_tb.sv
`timescale 1ns / 1ps
module pulse_train_gen_tb;
  localparam int MID = 8192;

  logic        clk, rst_n, start_i, soft_rst_i;
  logic [31:0] cfg_width_i, cfg_period_i;
  logic [15:0] cfg_count_i;
  logic [13:0] cfg_height_i;
  logic [13:0] dac_data_o;
  logic        dac_we_o, busy_o, pulse_start_o;
  int          n_chk = 0;
  int          n_fail = 0;

  pulse_train_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .soft_rst_i(soft_rst_i),
    .cfg_width_i(cfg_width_i), .cfg_period_i(cfg_period_i),
    .cfg_count_i(cfg_count_i), .cfg_height_i(cfg_height_i),
    .dac_data_o(dac_data_o), .dac_we_o(dac_we_o), .busy_o(busy_o),
    .pulse_start_o(pulse_start_o)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  function automatic int high_level(input int h);
    return (MID + h > 16383) ? 16383 : MID + h;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req, input int we_exp);
    chk(dac_data_o == MID, req, "data", dac_data_o, MID);
    chk(busy_o == 1'b0, req, "busy", busy_o, 0);
    chk(pulse_start_o == 1'b0, req, "pulse_start", pulse_start_o, 0);
    chk(dac_we_o == we_exp[0], req, "we", dac_we_o, we_exp);
  endtask

  // Plays one burst and compares every cycle with the model; optionally
  // injects a start strobe and new settings mid-burst (R10, R11).
  task automatic run_train(input int w, input int p, input int n, input int h,
                           input bit inject, input string dreq);
    int tot, lvl;
    tot = n * p;
    lvl = high_level(h);
    @(negedge clk);
    cfg_width_i = w; cfg_period_i = p; cfg_count_i = n; cfg_height_i = h;
    start_i = 1'b1;
    for (int m = 0; m <= tot + 3; m++) begin
      int t, ed, eb, ew, ep;
      bit act;
      @(negedge clk);
      start_i = 1'b0;
      t   = m - 1;
      act = (m >= 1) && (t < tot);
      eb  = (m < tot) ? 1 : 0;
      ed  = (act && (t % p) < w) ? lvl : MID;
      ep  = (act && (t % p) == 0 && w > 0) ? 1 : 0;
      ew  = (m >= 1 && t <= tot) ? 1 : 0;
      chk(busy_o == eb[0], "R5", "busy", busy_o, eb);
      chk(dac_data_o == ed, dreq, "data", dac_data_o, ed);
      chk(pulse_start_o == ep[0], "R7", "pulse_start", pulse_start_o, ep);
      chk(dac_we_o == ew[0], "R8", "we", dac_we_o, ew);
      if (inject && m == 1 && m < tot) begin
        start_i      = 1'b1;
        cfg_width_i  = $urandom_range(0, 12);
        cfg_period_i = $urandom_range(1, 10);
        cfg_count_i  = $urandom_range(1, 6);
        cfg_height_i = $urandom;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; soft_rst_i = 1'b0;
    cfg_width_i = '0; cfg_period_i = '0; cfg_count_i = '0; cfg_height_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1", 0);

    // R2/R3: directed basic burst
    run_train(3, 5, 3, 100, 1'b0, "R3");
    // R4: width equal to and above period
    run_train(4, 4, 2, 500, 1'b0, "R4");
    run_train(7, 4, 3, 500, 1'b0, "R4");
    // R6: saturation around the clip point
    run_train(2, 3, 1, 8190, 1'b0, "R6");
    run_train(2, 3, 1, 8191, 1'b0, "R6");
    run_train(2, 3, 2, 12000, 1'b0, "R6");
    // R3: zero width gives no pulses; period 1 gives a constant high level
    run_train(0, 4, 2, 300, 1'b0, "R3");
    run_train(1, 1, 5, 77, 1'b0, "R3");

    // Random bursts, half of them with mid-burst injection (R10, R11)
    for (int i = 0; i < 24; i++) begin
      run_train($urandom_range(0, 12), $urandom_range(1, 10),
                $urandom_range(1, 6), $urandom_range(0, 16383),
                i[0], "R3");
    end

    // R10: zero count and zero period leave the block idle
    @(negedge clk);
    cfg_width_i = 3; cfg_period_i = 5; cfg_count_i = 0; cfg_height_i = 10;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk_idle("R10", 0);
    cfg_count_i = 2; cfg_period_i = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk_idle("R10", 0);

    // R9: soft reset mid-burst together with a start strobe
    @(negedge clk);
    cfg_width_i = 3; cfg_period_i = 5; cfg_count_i = 4; cfg_height_i = 100;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    soft_rst_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    soft_rst_i = 1'b0; start_i = 1'b0;
    chk_idle("R9", 1);
    @(negedge clk);
    chk_idle("R10", 0);
    @(negedge clk);
    chk_idle("R10", 0);
    // R9: soft reset while idle writes nothing
    soft_rst_i = 1'b1;
    @(negedge clk);
    soft_rst_i = 1'b0;
    chk_idle("R9", 0);
    // R2: a new burst starts normally after the abort
    run_train(2, 4, 2, 50, 1'b0, "R2");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule